// File: doc/BRIEF.md
# Clock Output Selector with Test Divider

This block is the last stage in front of a bank of board clock outputs: processor, memory, PCI (gated and free-running), USB/IO, reference and interrupt-controller clocks. In normal operation it forwards the synthesized source clocks to their output groups. Each output has its own enable; an output that is switched off stays low. Each USB/IO output chooses between a full-rate 48 MHz source and a half-rate 24 MHz clock that the block derives by dividing that source by 2. The choice changes only where it cannot create a short pulse.

A two-bit mode field chooses how the outputs are fed. In test mode every output is derived from one external test clock. The processor, memory and USB-rate outputs get the test clock divided by 2. The PCI and IO-rate outputs get it divided by 4. The reference and interrupt-controller outputs get it undivided. In the high-impedance mode the shared output enable is dropped, so every pad floats. The enables, selects and the mode come from configuration register fields.

All clocks are handled as level signals and sampled by the block clock `clk_i`. Every enable register, select register and divider is a flop in that domain.

Top module: `clk_out_mux`

## Requirements
- R1: In normal mode (mode 2'b00, and likewise the unused code 2'b10), with every output enabled and every USB/IO select at 1, the CPU and SDRAM outputs equal `cpu_src_i`, the PCI and free-running PCI outputs equal `pci_src_i`, the REF and IOAPIC outputs equal `ref_src_i`, and each USB/IO output equals `usb48_src_i`.
- R2: An output whose enable bit is 0 stays at 0 while the other outputs keep running.
- R3: A new enable value takes effect only at a clock edge where that output's source sample is 0. The output then equals the source ANDed with the enable value held at that point.
- R4: In test mode (mode 2'b01), with k rising edges of `tclk_i` counted since the mode was entered, the CPU and SDRAM outputs equal bit 0 of k, the PCI and free-running PCI outputs equal bit 1 of k, and the REF and IOAPIC outputs equal `tclk_i`.
- R5: In test mode a USB/IO output whose select bit is 1 equals bit 0 of k (divide by 2). One whose select bit is 0 equals bit 1 of k (divide by 4).
- R6: Outside test mode both test dividers are held at zero, so when test mode is entered every divided output starts at 0, phase-aligned.
- R7: `oe_o` is 0 in mode 2'b11 and 1 in every other mode.
- R8: In normal mode a USB/IO output whose select bit is 0 gives one rising edge for every two rising edges of `usb48_src_i`.
- R9: A USB/IO select changes only at an edge where both the 48 MHz source and the 24 MHz clock are 0. While the select toggles, no output level lasts fewer cycles than one 48 MHz half-period.
- R10: While `rst_ni` is 0 every clock output is 0. After reset each USB/IO selector starts at 48 MHz (select 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 00 normal, 01 test, 11 high impedance, 10 acts as normal |
| tclk_i | input | 1 | External test clock |
| cpu_src_i | input | 1 | Synthesized CPU/SDRAM clock |
| pci_src_i | input | 1 | Synthesized PCI clock |
| usb48_src_i | input | 1 | Synthesized 48 MHz clock |
| ref_src_i | input | 1 | Reference oscillator clock |
| cpu_en_i | input | N_CPU | Per-output CPU enables |
| sdram_en_i | input | N_SDRAM | Per-output SDRAM enables |
| pci_en_i | input | N_PCI | Per-output PCI enables |
| pcif_en_i | input | 1 | Free-running PCI enable |
| usb_en_i | input | N_USB | Per-output USB/IO enables |
| usb_sel_i | input | N_USB | 1 selects 48 MHz, 0 selects 24 MHz |
| ref_en_i | input | N_REF | Per-output REF enables |
| apic_en_i | input | 1 | IOAPIC enable |
| cpu_o | output | N_CPU | CPU clocks |
| sdram_o | output | N_SDRAM | SDRAM clocks |
| pci_o | output | N_PCI | PCI clocks |
| pcif_o | output | 1 | Free-running PCI clock |
| usb_o | output | N_USB | USB/IO clocks |
| ref_o | output | N_REF | Reference clocks |
| apic_o | output | 1 | IOAPIC clock |
| oe_o | output | 1 | Shared pad output enable |

## Verification
The assertions assume that every source clock and the test clock hold each level for at least two `clk_i` cycles, so that each rising edge is sampled exactly once. They also assume that enables, selects and the mode change only between clock edges. The bench builds every source from one cycle counter, with half-periods of two, three, four and five cycles. It changes the configuration fields only at the sample point after a rising edge, which keeps all stimulus inside those assumptions.

// File: rtl/clk_out_pkg.sv
package clk_out_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_TEST   = 2'b01,
    MODE_RSVD   = 2'b10,
    MODE_HIZ    = 2'b11
  } out_mode_e;
endpackage

// File: rtl/clk_test_div.sv
module clk_test_div (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tclk_i,
  output logic div2_o,
  output logic div4_o
);
  logic       tclk_q;
  logic [1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tclk_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      tclk_q <= tclk_i;
      if (!run_i)                 cnt_q <= '0;
      else if (tclk_i && !tclk_q) cnt_q <= cnt_q + 2'd1;
    end
  end

  assign div2_o = cnt_q[0];
  assign div4_o = cnt_q[1];

  // R6
  div_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!div2_o && !div4_o));
  // R4
  div_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div2_o != $past(div2_o)) |-> ($past(tclk_i) || !$past(run_i)));
endmodule

// File: rtl/clk_half_div.sv
module clk_half_div (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  output logic div_o
);
  logic src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= 1'b0;
      div_o <= 1'b0;
    end else begin
      src_q <= src_i;
      if (src_i && !src_q) div_o <= ~div_o;
    end
  end

  // R8
  half_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_o != $past(div_o)) |-> ($past(src_i) && !$past(src_i, 2)));
endmodule

// File: rtl/clk_sel_glitchless.sv
module clk_sel_glitchless (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fast_i,
  input  logic slow_i,
  input  logic sel_i,
  output logic clk_o
);
  logic sel_q;

  // switch only while both candidates are low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                sel_q <= 1'b1;
    else if (!fast_i && !slow_i) sel_q <= sel_i;
  end

  assign clk_o = sel_q ? fast_i : slow_i;

  // R9
  sel_safe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q != $past(sel_q)) |-> (!$past(fast_i) && !$past(slow_i)));
endmodule

// File: rtl/clk_gate_bank.sv
module clk_gate_bank #(
  parameter int N = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] clk_o
);
  logic [N-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else begin
      for (int i = 0; i < N; i++)
        if (!src_i[i]) en_q[i] <= en_i[i];
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_gate
    assign clk_o[g] = src_i[g] & en_q[g];

    // R3
    gate_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_q[g] != $past(en_q[g])) |-> !$past(src_i[g]));
    // R2
    gate_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_i[g] && !src_i[g]) |=> !clk_o[g]);
  end
endmodule

// File: rtl/clk_out_mux.sv
module clk_out_mux #(
  parameter int N_CPU   = 4,
  parameter int N_SDRAM = 8,
  parameter int N_PCI   = 6,
  parameter int N_USB   = 2,
  parameter int N_REF   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         mode_i,
  input  logic               tclk_i,
  input  logic               cpu_src_i,
  input  logic               pci_src_i,
  input  logic               usb48_src_i,
  input  logic               ref_src_i,
  input  logic [N_CPU-1:0]   cpu_en_i,
  input  logic [N_SDRAM-1:0] sdram_en_i,
  input  logic [N_PCI-1:0]   pci_en_i,
  input  logic               pcif_en_i,
  input  logic [N_USB-1:0]   usb_en_i,
  input  logic [N_USB-1:0]   usb_sel_i,
  input  logic [N_REF-1:0]   ref_en_i,
  input  logic               apic_en_i,
  output logic [N_CPU-1:0]   cpu_o,
  output logic [N_SDRAM-1:0] sdram_o,
  output logic [N_PCI-1:0]   pci_o,
  output logic               pcif_o,
  output logic [N_USB-1:0]   usb_o,
  output logic [N_REF-1:0]   ref_o,
  output logic               apic_o,
  output logic               oe_o
);
  import clk_out_pkg::*;

  localparam int OFF_SD   = N_CPU;
  localparam int OFF_PCI  = OFF_SD + N_SDRAM;
  localparam int OFF_PCIF = OFF_PCI + N_PCI;
  localparam int OFF_USB  = OFF_PCIF + 1;
  localparam int OFF_REF  = OFF_USB + N_USB;
  localparam int OFF_APIC = OFF_REF + N_REF;
  localparam int N_ALL    = OFF_APIC + 1;

  out_mode_e mode;
  logic test, tdiv2, tdiv4, usb24;
  logic cpu_s, pci_s, ref_s, usb_fast, usb_slow;
  logic [N_USB-1:0] usb_s;
  logic [N_ALL-1:0] src_all, en_all, out_all;

  assign mode = out_mode_e'(mode_i);
  assign test = (mode == MODE_TEST);
  assign oe_o = (mode != MODE_HIZ);

  clk_test_div u_tdiv (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(test), .tclk_i(tclk_i),
    .div2_o(tdiv2), .div4_o(tdiv4)
  );

  clk_half_div u_usb24 (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(usb48_src_i), .div_o(usb24)
  );

  // per-class source selection
  assign cpu_s    = test ? tdiv2  : cpu_src_i;
  assign pci_s    = test ? tdiv4  : pci_src_i;
  assign ref_s    = test ? tclk_i : ref_src_i;
  assign usb_fast = test ? tdiv2  : usb48_src_i;
  assign usb_slow = test ? tdiv4  : usb24;

  for (genvar g = 0; g < N_USB; g++) begin : g_usb
    clk_sel_glitchless u_sel (
      .clk_i(clk_i), .rst_ni(rst_ni), .fast_i(usb_fast), .slow_i(usb_slow),
      .sel_i(usb_sel_i[g]), .clk_o(usb_s[g])
    );
  end

  assign src_all = {ref_s, {N_REF{ref_s}}, usb_s, pci_s, {N_PCI{pci_s}},
                    {N_SDRAM{cpu_s}}, {N_CPU{cpu_s}}};
  assign en_all  = {apic_en_i, ref_en_i, usb_en_i, pcif_en_i, pci_en_i,
                    sdram_en_i, cpu_en_i};

  clk_gate_bank #(.N(N_ALL)) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_all), .en_i(en_all), .clk_o(out_all)
  );

  assign cpu_o   = out_all[N_CPU-1:0];
  assign sdram_o = out_all[OFF_PCI-1:OFF_SD];
  assign pci_o   = out_all[OFF_PCIF-1:OFF_PCI];
  assign pcif_o  = out_all[OFF_PCIF];
  assign usb_o   = out_all[OFF_REF-1:OFF_USB];
  assign ref_o   = out_all[OFF_APIC-1:OFF_REF];
  assign apic_o  = out_all[OFF_APIC];

  // R10
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (out_all == '0));
  // R4
  test_ref_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test && apic_en_i && $past(apic_en_i) && $past(test) && !$past(tclk_i))
      |-> (apic_o == tclk_i));
endmodule

// File: tb/sim_clk_out_mux.sv
module sim_clk_out_mux;
  localparam int NC = 4, NS = 8, NP = 6, NU = 2, NR = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0] mode = 2'b00;
  logic tclk = 0, cpu_src = 0, pci_src = 0, usb48 = 0, ref_src = 0;
  logic [NC-1:0] cpu_en = '1;
  logic [NS-1:0] sdram_en = '1;
  logic [NP-1:0] pci_en = '1;
  logic pcif_en = 1, apic_en = 1;
  logic [NU-1:0] usb_en = '1, usb_sel = '1;
  logic [NR-1:0] ref_en = '1;
  logic [NC-1:0] cpu_o;
  logic [NS-1:0] sdram_o;
  logic [NP-1:0] pci_o;
  logic pcif_o, apic_o, oe_o;
  logic [NU-1:0] usb_o;
  logic [NR-1:0] ref_o;

  clk_out_mux #(.N_CPU(NC), .N_SDRAM(NS), .N_PCI(NP), .N_USB(NU), .N_REF(NR)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .tclk_i(tclk),
    .cpu_src_i(cpu_src), .pci_src_i(pci_src), .usb48_src_i(usb48), .ref_src_i(ref_src),
    .cpu_en_i(cpu_en), .sdram_en_i(sdram_en), .pci_en_i(pci_en), .pcif_en_i(pcif_en),
    .usb_en_i(usb_en), .usb_sel_i(usb_sel), .ref_en_i(ref_en), .apic_en_i(apic_en),
    .cpu_o(cpu_o), .sdram_o(sdram_o), .pci_o(pci_o), .pcif_o(pcif_o),
    .usb_o(usb_o), .ref_o(ref_o), .apic_o(apic_o), .oe_o(oe_o)
  );

  int checks = 0, errors = 0, cyc = 0, k = 0;
  logic eq0 = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive sources at negedge, sample 1 ns after the following posedge
  task automatic step();
    logic nt;
    @(negedge clk);
    cyc++;
    cpu_src = cyc[1];
    pci_src = cyc[2];
    usb48   = ((cyc / 3) % 2) == 1;
    ref_src = ((cyc / 5) % 2) == 1;
    nt      = cyc[1];
    if (mode == 2'b01) begin
      if (nt && !tclk) k++;
    end else k = 0;
    tclk = nt;
    if (!rst_n) eq0 = 1'b0;
    else if (!cpu_src) eq0 = cpu_en[0];
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int r48, ru, run, minrun;
    logic prev48, prevu;
    bit started;
    // R10 reset state
    repeat (6) step();
    chk({cpu_o, sdram_o, pci_o, pcif_o, usb_o, ref_o, apic_o} == '0, "R10 outputs low in reset",
        int'({cpu_o, pci_o}), 0);
    chk(oe_o == 1'b1, "R7 oe in normal", oe_o, 1);
    rst_n = 1'b1;
    repeat (12) step();

    // R1 passthrough
    for (int i = 0; i < 40; i++) begin
      step();
      chk(cpu_o == {NC{cpu_src}} && sdram_o == {NS{cpu_src}}, "R1 cpu/sdram",
          int'(cpu_o), int'({NC{cpu_src}}));
      chk(pci_o == {NP{pci_src}} && pcif_o == pci_src, "R1 pci", int'(pci_o), int'({NP{pci_src}}));
      chk(ref_o == {NR{ref_src}} && apic_o == ref_src, "R1 ref/apic", int'(ref_o), int'({NR{ref_src}}));
      chk(usb_o == {NU{usb48}}, "R1 usb 48", int'(usb_o), int'({NU{usb48}}));
    end
    mode = 2'b10;
    step();
    chk(oe_o == 1'b1, "R7 oe in code 10", oe_o, 1);
    chk(cpu_o == {NC{cpu_src}}, "R1 code 10 acts normal", int'(cpu_o), int'({NC{cpu_src}}));
    mode = 2'b00;

    // R8 24 MHz rate
    usb_sel = '0;
    repeat (14) step();
    r48 = 0; ru = 0; prev48 = usb48; prevu = usb_o[1];
    for (int i = 0; i < 120; i++) begin
      step();
      if (usb48 && !prev48) r48++;
      if (usb_o[1] && !prevu) ru++;
      prev48 = usb48; prevu = usb_o[1];
    end
    chk((2 * ru >= r48 - 2) && (2 * ru <= r48 + 2), "R8 24MHz edge ratio", 2 * ru, r48);

    // R9 select toggling, minimum level length 3 cycles
    started = 0; run = 0; minrun = 1000; prevu = usb_o[0];
    for (int i = 0; i < 168; i++) begin
      if (i % 7 == 0) usb_sel[0] = ~usb_sel[0];
      step();
      if (usb_o[0] != prevu) begin
        if (started && run < minrun) minrun = run;
        started = 1; run = 1;
      end else run++;
      prevu = usb_o[0];
    end
    chk(minrun >= 3, "R9 min level length", minrun, 3);
    usb_sel = '1;
    repeat (12) step();

    // R2 disabled outputs held low
    cpu_en = 4'b1101; pci_en = 6'b111110; ref_en = 2'b01; usb_en = 2'b10;
    repeat (10) step();
    for (int i = 0; i < 24; i++) begin
      step();
      chk(cpu_o[1] == 1'b0 && pci_o[0] == 1'b0 && ref_o[1] == 1'b0 && usb_o[0] == 1'b0,
          "R2 disabled low", int'({cpu_o[1], pci_o[0], ref_o[1], usb_o[0]}), 0);
      chk(cpu_o[0] == cpu_src && pci_o[1] == pci_src, "R2 neighbours run",
          int'({cpu_o[0], pci_o[1]}), int'({cpu_src, pci_src}));
    end

    // R3 enable takes effect only while source low
    for (int i = 0; i < 48; i++) begin
      if (i % 3 == 0) cpu_en[0] = ~cpu_en[0];
      step();
      chk(cpu_o[0] == (cpu_src & eq0), "R3 gated enable", cpu_o[0], cpu_src & eq0);
    end
    cpu_en = '1; pci_en = '1; ref_en = '1; usb_en = '1;
    repeat (12) step();

    // R4/R5/R6 test mode
    usb_sel = 2'b10;
    mode = 2'b01;
    step();
    chk(cpu_o == '0 && pci_o == '0 && usb_o == '0, "R6 aligned start",
        int'({cpu_o, pci_o, usb_o}), 0);
    chk(oe_o == 1'b1, "R7 oe in test", oe_o, 1);
    for (int i = 0; i < 64; i++) begin
      step();
      chk(cpu_o == {NC{k[0]}} && sdram_o == {NS{k[0]}}, "R4 cpu/sdram div2",
          int'(cpu_o), int'({NC{k[0]}}));
      chk(pci_o == {NP{k[1]}} && pcif_o == k[1], "R4 pci div4", int'(pci_o), int'({NP{k[1]}}));
      chk(ref_o == {NR{tclk}} && apic_o == tclk, "R4 ref/apic div1", int'(ref_o), int'({NR{tclk}}));
      chk(usb_o[1] == k[0] && usb_o[0] == k[1], "R5 usb div2 / io div4",
          int'(usb_o), int'({k[0], k[1]}));
    end

    // R6 re-entry after leaving test mode
    mode = 2'b00;
    repeat (5) step();
    mode = 2'b01;
    step();
    chk(cpu_o == {NC{k[0]}} && pci_o == {NP{k[1]}}, "R6 re-entry phase",
        int'({cpu_o, pci_o}), int'({{NC{k[0]}}, {NP{k[1]}}}));

    // R7 high impedance
    mode = 2'b11;
    step();
    chk(oe_o == 1'b0, "R7 oe in hiz", oe_o, 0);
    mode = 2'b00;
    step();
    chk(oe_o == 1'b1, "R7 oe back to normal", oe_o, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule